// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides how a processor core enters an exception handler. The core raises a fault with a cause code, the faulting PC and, where it applies, a faulting virtual address. The controller then chooses one of four handler vectors (user, kernel, double or debug) and records the event in a small set of special registers: saved PCs, saved status words, the cause, the fault address and a debug cause. It owns the processor-status word and drives it out to the core. The exception-mode bit in that word separates a first fault from a fault raised while a handler is already running.

Debug requests are gated by priority. A request is taken only when the current interrupt level is below the requested debug level. It then saves the PC and status into the per-level registers for that level and raises the interrupt level. Software reaches every register through a small special-register port, with a registered read path. Through that port it inspects the saved state and restores the status word when it returns from the exception.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, the status word, every saved register and the read data are zero, and no vector is selected.
- R2: An exception taken with the exception-mode bit (status bit 4) clear saves the PC in level-1 saved-PC. It selects the user vector (vec_o = 4'b0001) when the user-mode bit (status bit 5) is set, and the kernel vector (vec_o = 4'b0010) when it is clear.
- R3: An exception taken with the exception-mode bit set selects the double vector (vec_o = 4'b0100). The PC goes to the double-exception PC register when HAS_DEPC is 1, and to level-1 saved-PC when HAS_DEPC is 0.
- R4: Every exception that is taken writes the cause register and sets the exception-mode bit. All other status bits keep their values.
- R5: For a generic fault (kind 0) the cause comes from cause_i. The fault-address register takes vaddr_i only when vaddr_vld_i is high; otherwise it keeps its value.
- R6: A misaligned access (kind 1) raises cause CAUSE_ALIGN (9) with vaddr_i as the fault address. This happens only when UNALIGNED_EXC is 1 and HW_ALIGN is 0. Otherwise the strobe selects no vector and changes no register.
- R7: A bus error on instruction fetch (kind 2) records cause CAUSE_IFETCH (12) with pc_i as the fault address. A bus error on a data access (kind 3) records cause CAUSE_LSERR (13) with vaddr_i.
- R8: A debug request is accepted only when the status interrupt level (bits 3:0) is strictly below the debug level L, and L lies in 2..NLVL. A request that is not accepted changes nothing.
- R9: On debug entry the PC goes to saved-PC L, the old status word to saved-status L and dbg_cause_i to the debug-cause register. The interrupt level becomes L, the exception-mode bit is set and the debug vector is selected (vec_o = 4'b1000).
- R10: When an exception and a debug request arrive in the same cycle, the exception is taken and the debug request is held pending. The pending request is taken in the next cycle without a new raise, using that cycle's pc_i.
- R11: vec_o is one-hot or zero. It is asserted for the single cycle that follows the edge at which the event was taken, when the new status word is already visible on ps_o.
- R12: Register addresses: status 0, cause 1, fault address 2, double-exception PC 3, debug cause 4, saved-PC n at 8+n, saved-status n at 16+n. Unmapped addresses read as zero. Read data appears one cycle after the address is presented. A software write in a cycle that takes an event is dropped.
- R13: Saved registers and the status word hold their values unless software writes them or an event is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | Fault strobe |
| kind_i | input | 2 | Fault kind: 0 generic, 1 misaligned, 2 fetch bus error, 3 data bus error |
| cause_i | input | CAUSE_W | Cause code for a generic fault |
| pc_i | input | XLEN | PC of the faulting or interrupted instruction |
| vaddr_i | input | XLEN | Faulting data virtual address |
| vaddr_vld_i | input | 1 | Generic fault carries an address |
| dbg_req_i | input | 1 | Debug request strobe |
| dbg_cause_i | input | CAUSE_W | Debug cause code |
| dbg_level_i | input | 4 | Debug priority level L |
| sr_we_i | input | 1 | Special-register write enable |
| sr_addr_i | input | 5 | Special-register address |
| sr_wdata_i | input | XLEN | Special-register write data |
| sr_rdata_o | output | XLEN | Registered special-register read data |
| ps_o | output | 8 | Current processor-status word |
| vec_o | output | 4 | One-hot vector select: user, kernel, double, debug |

## Verification
The status word, the saved registers and vec_o all change at the clock edge that samples the event. The bench therefore drives the strobes on a falling edge and reads vec_o and ps_o on the next falling edge. It samples one falling edge later again to confirm that the vector has dropped. Register contents come back through the read port, which adds one more edge: the address is driven on a falling edge and the data is sampled on the following one. For a coincident exception and debug request, the bench expects the exception vector one cycle after the strobe and the debug vector the cycle after that.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
  localparam int LVL_W       = 4;
  localparam int PS_W        = 8;
  localparam int PS_ILVL_LSB = 0;
  localparam int PS_EXCM     = 4;
  localparam int PS_UM       = 5;
  localparam int SR_AW       = 5;

  localparam logic [SR_AW-1:0] SRA_PS       = 5'd0;
  localparam logic [SR_AW-1:0] SRA_CAUSE    = 5'd1;
  localparam logic [SR_AW-1:0] SRA_FADDR    = 5'd2;
  localparam logic [SR_AW-1:0] SRA_DEPC     = 5'd3;
  localparam logic [SR_AW-1:0] SRA_DBGC     = 5'd4;
  localparam logic [SR_AW-1:0] SRA_EPC_BASE = 5'd8;
  localparam logic [SR_AW-1:0] SRA_EPS_BASE = 5'd16;

  typedef enum logic [3:0] {
    VEC_NONE   = 4'b0000,
    VEC_USER   = 4'b0001,
    VEC_KERNEL = 4'b0010,
    VEC_DOUBLE = 4'b0100,
    VEC_DEBUG  = 4'b1000
  } vec_e;

  localparam logic [1:0] FK_GENERIC   = 2'd0;
  localparam logic [1:0] FK_MISALIGN  = 2'd1;
  localparam logic [1:0] FK_BUS_FETCH = 2'd2;
  localparam logic [1:0] FK_BUS_DATA  = 2'd3;
endpackage

// File: rtl/exc_cause_sel.sv
`timescale 1ns/1ps
// Maps a fault kind onto a taken flag, cause code and fault address.
module exc_cause_sel import exc_entry_pkg::*; #(
  parameter int XLEN          = 32,
  parameter int CAUSE_W       = 6,
  parameter int UNALIGNED_EXC = 1,
  parameter int HW_ALIGN      = 0,
  parameter int CAUSE_ALIGN   = 9,
  parameter int CAUSE_IFETCH  = 12,
  parameter int CAUSE_LSERR   = 13
) (
  input  logic               raise_i,
  input  logic [1:0]         kind_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    vaddr_i,
  input  logic               vaddr_vld_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    addr_o,
  output logic               addr_we_o
);
  localparam bit ALIGN_TRAP = (UNALIGNED_EXC != 0) && (HW_ALIGN == 0);

  logic addr_want;

  always_comb begin
    take_o    = raise_i;
    cause_o   = cause_i;
    addr_o    = vaddr_i;
    addr_want = vaddr_vld_i;
    case (kind_i)
      FK_MISALIGN: begin
        take_o    = raise_i && ALIGN_TRAP;
        cause_o   = CAUSE_W'(CAUSE_ALIGN);
        addr_want = 1'b1;
      end
      FK_BUS_FETCH: begin
        cause_o   = CAUSE_W'(CAUSE_IFETCH);
        addr_o    = pc_i;
        addr_want = 1'b1;
      end
      FK_BUS_DATA: begin
        cause_o   = CAUSE_W'(CAUSE_LSERR);
        addr_want = 1'b1;
      end
      default: ;
    endcase
    addr_we_o = addr_want && take_o;
  end
endmodule

// File: rtl/exc_route.sv
`timescale 1ns/1ps
// Vector choice for ordinary faults and the debug priority gate.
module exc_route import exc_entry_pkg::*; #(
  parameter int NLVL = 6
) (
  input  logic [PS_W-1:0]  ps_i,
  input  logic [LVL_W-1:0] dbg_level_i,
  output vec_e             ord_vec_o,
  output logic             dbg_ok_o
);
  logic [LVL_W-1:0] cur_lvl;
  assign cur_lvl = ps_i[PS_ILVL_LSB +: LVL_W];

  always_comb begin
    if (ps_i[PS_EXCM])    ord_vec_o = VEC_DOUBLE;
    else if (ps_i[PS_UM]) ord_vec_o = VEC_USER;
    else                  ord_vec_o = VEC_KERNEL;
  end

  assign dbg_ok_o = (dbg_level_i >= LVL_W'(2)) &&
                    (int'(dbg_level_i) <= NLVL) &&
                    (cur_lvl < dbg_level_i);
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl import exc_entry_pkg::*; #(
  parameter int XLEN          = 32,
  parameter int CAUSE_W       = 6,
  parameter int NLVL          = 6,
  parameter int HAS_DEPC      = 1,
  parameter int UNALIGNED_EXC = 1,
  parameter int HW_ALIGN      = 0,
  parameter int CAUSE_ALIGN   = 9,
  parameter int CAUSE_IFETCH  = 12,
  parameter int CAUSE_LSERR   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise_i,
  input  logic [1:0]         kind_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    vaddr_i,
  input  logic               vaddr_vld_i,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic [LVL_W-1:0]   dbg_level_i,
  input  logic               sr_we_i,
  input  logic [SR_AW-1:0]   sr_addr_i,
  input  logic [XLEN-1:0]    sr_wdata_i,
  output logic [XLEN-1:0]    sr_rdata_o,
  output logic [PS_W-1:0]    ps_o,
  output logic [3:0]         vec_o
);
  logic [PS_W-1:0]    ps_q, ps_d;
  logic [CAUSE_W-1:0] cause_q, dbgc_q, pcause_q;
  logic [XLEN-1:0]    faddr_q, depc_q, rd_d;
  logic [XLEN-1:0]    epc_q [1:NLVL];
  logic [PS_W-1:0]    eps_q [1:NLVL];
  logic               pend_q;
  vec_e               vec_q, vec_d, ord_vec;

  logic               exc_take, exc_addr_we, dbg_ok, dbg_any, ev_exc, ev_dbg, sw_we;
  logic [CAUSE_W-1:0] exc_cause, dbg_cause_eff;
  logic [XLEN-1:0]    exc_addr;

  exc_cause_sel #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .UNALIGNED_EXC(UNALIGNED_EXC), .HW_ALIGN(HW_ALIGN),
    .CAUSE_ALIGN(CAUSE_ALIGN), .CAUSE_IFETCH(CAUSE_IFETCH), .CAUSE_LSERR(CAUSE_LSERR)
  ) u_sel (
    .raise_i(raise_i), .kind_i(kind_i), .cause_i(cause_i), .pc_i(pc_i),
    .vaddr_i(vaddr_i), .vaddr_vld_i(vaddr_vld_i), .take_o(exc_take),
    .cause_o(exc_cause), .addr_o(exc_addr), .addr_we_o(exc_addr_we)
  );

  exc_route #(.NLVL(NLVL)) u_route (
    .ps_i(ps_q), .dbg_level_i(dbg_level_i), .ord_vec_o(ord_vec), .dbg_ok_o(dbg_ok)
  );

  // Event arbitration: an ordinary fault wins over debug, and any event wins over software.
  assign ev_exc        = exc_take;
  assign dbg_any       = dbg_req_i || pend_q;
  assign dbg_cause_eff = dbg_req_i ? dbg_cause_i : pcause_q;
  assign ev_dbg        = !ev_exc && dbg_any && dbg_ok;
  assign sw_we         = sr_we_i && !ev_exc && !ev_dbg;

  always_comb begin
    ps_d  = ps_q;
    vec_d = VEC_NONE;
    if (ev_exc) begin
      ps_d[PS_EXCM] = 1'b1;
      vec_d         = ord_vec;
    end else if (ev_dbg) begin
      ps_d[PS_ILVL_LSB +: LVL_W] = dbg_level_i;
      ps_d[PS_EXCM]              = 1'b1;
      vec_d                      = VEC_DEBUG;
    end else if (sw_we && sr_addr_i == SRA_PS) begin
      ps_d = sr_wdata_i[PS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q     <= '0;
      cause_q  <= '0;
      dbgc_q   <= '0;
      pcause_q <= '0;
      faddr_q  <= '0;
      pend_q   <= 1'b0;
      vec_q    <= VEC_NONE;
      for (int n = 1; n <= NLVL; n++) begin
        epc_q[n] <= '0;
        eps_q[n] <= '0;
      end
    end else begin
      ps_q  <= ps_d;
      vec_q <= vec_d;
      if (ev_exc) begin
        cause_q  <= exc_cause;
        pend_q   <= dbg_any;
        pcause_q <= dbg_cause_eff;
        if (exc_addr_we) faddr_q <= exc_addr;
        if (!ps_q[PS_EXCM] || HAS_DEPC == 0) epc_q[1] <= pc_i;
      end else begin
        pend_q <= 1'b0;
        if (ev_dbg) dbgc_q <= dbg_cause_eff;
        if (sw_we && sr_addr_i == SRA_CAUSE) cause_q <= sr_wdata_i[CAUSE_W-1:0];
        if (sw_we && sr_addr_i == SRA_FADDR) faddr_q <= sr_wdata_i;
        if (sw_we && sr_addr_i == SRA_DBGC)  dbgc_q  <= sr_wdata_i[CAUSE_W-1:0];
      end
      for (int n = 1; n <= NLVL; n++) begin
        if (ev_dbg && int'(dbg_level_i) == n) begin
          epc_q[n] <= pc_i;
          eps_q[n] <= ps_q;
        end else if (sw_we && sr_addr_i == SRA_EPC_BASE + SR_AW'(n)) begin
          epc_q[n] <= sr_wdata_i;
        end else if (sw_we && sr_addr_i == SRA_EPS_BASE + SR_AW'(n)) begin
          eps_q[n] <= sr_wdata_i[PS_W-1:0];
        end
      end
    end
  end

  // The double-exception PC register exists only when the configuration asks for it.
  generate
    if (HAS_DEPC != 0) begin : g_depc
      always_ff @(posedge clk) begin
        if (rst)                                    depc_q <= '0;
        else if (ev_exc && ps_q[PS_EXCM])           depc_q <= pc_i;
        else if (sw_we && sr_addr_i == SRA_DEPC)    depc_q <= sr_wdata_i;
      end
    end else begin : g_no_depc
      assign depc_q = '0;
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    case (sr_addr_i)
      SRA_PS:    rd_d = XLEN'(ps_q);
      SRA_CAUSE: rd_d = XLEN'(cause_q);
      SRA_FADDR: rd_d = faddr_q;
      SRA_DEPC:  rd_d = depc_q;
      SRA_DBGC:  rd_d = XLEN'(dbgc_q);
      default:   rd_d = '0;
    endcase
    for (int n = 1; n <= NLVL; n++) begin
      if (sr_addr_i == SRA_EPC_BASE + SR_AW'(n)) rd_d = epc_q[n];
      if (sr_addr_i == SRA_EPS_BASE + SR_AW'(n)) rd_d = XLEN'(eps_q[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr_rdata_o <= '0;
    else     sr_rdata_o <= rd_d;
  end

  assign ps_o  = ps_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk import exc_entry_pkg::*; #(
  parameter int NLVL = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      vec_o,
  input logic [PS_W-1:0] ps_o,
  input logic            sr_we_i
);
  AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_o)); // R11

  AST_VEC_SETS_EXCM: assert property (@(posedge clk) disable iff (rst)
    (vec_o != 4'b0000) |-> ps_o[PS_EXCM]); // R4

  AST_DOUBLE_NEEDS_EXCM: assert property (@(posedge clk) disable iff (rst)
    (vec_o == 4'b0100) |-> $past(ps_o[PS_EXCM])); // R3

  AST_USER_FROM_UM: assert property (@(posedge clk) disable iff (rst)
    (vec_o == 4'b0001) |-> ($past(ps_o[PS_UM]) && !$past(ps_o[PS_EXCM]))); // R2

  AST_DBG_RAISES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (vec_o == 4'b1000) |->
      ($past(ps_o[PS_ILVL_LSB +: LVL_W]) < ps_o[PS_ILVL_LSB +: LVL_W])); // R8

  AST_DBG_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (vec_o == 4'b1000) |->
      (ps_o[PS_ILVL_LSB +: LVL_W] >= LVL_W'(2) && int'(ps_o[PS_ILVL_LSB +: LVL_W]) <= NLVL)); // R9

  AST_PS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (vec_o == 4'b0000 && !$past(sr_we_i)) |-> $stable(ps_o)); // R13
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.NLVL(NLVL)) u_chk (
  .clk(clk), .rst(rst), .vec_o(vec_o), .ps_o(ps_o), .sr_we_i(sr_we_i)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise = 0, vv = 0, dbg = 0, we = 0;
  logic [1:0]  kind = 0;
  logic [5:0]  cause = 0, dcause = 0;
  logic [31:0] pc = 0, va = 0, wdata = 0;
  logic [3:0]  dlvl = 0;
  logic [4:0]  addr = 0;
  logic [31:0] rd_a, rd_b;
  logic [7:0]  ps_a, ps_b;
  logic [3:0]  vec_a, vec_b;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0]  vcap_a, vcap_b, vnext_a;
  logic [7:0]  pscap_a;
  logic [31:0] ra, rb;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .raise_i(raise), .kind_i(kind), .cause_i(cause), .pc_i(pc),
    .vaddr_i(va), .vaddr_vld_i(vv), .dbg_req_i(dbg), .dbg_cause_i(dcause),
    .dbg_level_i(dlvl), .sr_we_i(we), .sr_addr_i(addr), .sr_wdata_i(wdata),
    .sr_rdata_o(rd_a), .ps_o(ps_a), .vec_o(vec_a));

  exc_entry_ctrl #(.HAS_DEPC(0), .HW_ALIGN(1)) u_dut_b (
    .clk(clk), .rst(rst), .raise_i(raise), .kind_i(kind), .cause_i(cause), .pc_i(pc),
    .vaddr_i(va), .vaddr_vld_i(vv), .dbg_req_i(dbg), .dbg_cause_i(dcause),
    .dbg_level_i(dlvl), .sr_we_i(we), .sr_addr_i(addr), .sr_wdata_i(wdata),
    .sr_rdata_o(rd_b), .ps_o(ps_b), .vec_o(vec_b));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); addr = a;
    @(negedge clk); ra = rd_a; rb = rd_b;
  endtask

  task automatic fire(input logic r, input logic [1:0] k, input logic [5:0] c,
                      input logic [31:0] p, input logic [31:0] v, input logic vvl,
                      input logic d, input logic [5:0] dc, input logic [3:0] l);
    @(negedge clk);
    raise = r; kind = k; cause = c; pc = p; va = v; vv = vvl; dbg = d; dcause = dc; dlvl = l;
    @(negedge clk);
    vcap_a = vec_a; vcap_b = vec_b; pscap_a = ps_a;
    raise = 0; dbg = 0; vv = 0;
    @(negedge clk);
    vnext_a = vec_a;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired got %0d exp %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  ps0, ps_exp;
    logic [31:0] p, v, cexp, fexp, e1exp, dexp;
    logic [5:0]  cin;
    logic [3:0]  vexp;
    int um, ex, k, vvb, hasdepc, hwal;
    logic [31:0] g_ps[2], g_c[2], g_f[2], g_e1[2], g_d[2];
    logic [3:0]  g_v[2];
    bit take;

    repeat (4) @(negedge clk);
    chk("R1 vec in reset", {28'd0, vec_a}, 32'd0);
    chk("R1 ps in reset", {24'd0, ps_a}, 32'd0);
    rst = 0;
    for (int a = 0; a < 32; a++) begin
      rd(a[4:0]);
      chk($sformatf("R1 reg %0d dut a", a), ra, 32'd0);
      chk($sformatf("R1 reg %0d dut b", a), rb, 32'd0);
    end

    // R12 plain write and read back; unmapped address stays zero
    wr(5'd2, 32'h1234_5678);
    rd(5'd2); chk("R12 faddr readback", ra, 32'h1234_5678);
    wr(5'd7, 32'hFFFF_FFFF);
    rd(5'd7); chk("R12 unmapped reads zero", ra, 32'd0);

    // Sweep of status mode bits, fault kinds and address-valid flag (R2..R7, R11)
    for (int it = 0; it < 32; it++) begin
      um = it & 1; ex = (it >> 1) & 1; k = (it >> 2) & 3; vvb = (it >> 4) & 1;
      ps0 = 8'((um << 5) | (ex << 4) | 2);
      p   = 32'h0000_1000 + 32'(it * 16);
      v   = 32'h8000_0000 + 32'(it);
      cin = 6'(20 + it);
      wr(5'd0, {24'd0, ps0});
      wr(5'd1, 32'h3F);
      wr(5'd2, 32'h5A5A_0000);
      wr(5'd9, 32'd0);
      wr(5'd3, 32'd0);
      fire(1'b1, k[1:0], cin, p, v, vvb[0], 1'b0, 6'd0, 4'd0);
      g_v[0] = vcap_a; g_v[1] = vcap_b;
      chk("R11 vector drops after one cycle", {28'd0, vnext_a}, 32'd0);
      rd(5'd0); g_ps[0] = ra; g_ps[1] = rb;
      rd(5'd1); g_c[0]  = ra; g_c[1]  = rb;
      rd(5'd2); g_f[0]  = ra; g_f[1]  = rb;
      rd(5'd9); g_e1[0] = ra; g_e1[1] = rb;
      rd(5'd3); g_d[0]  = ra; g_d[1]  = rb;
      for (int cfg = 0; cfg < 2; cfg++) begin
        hasdepc = (cfg == 0) ? 1 : 0;
        hwal    = (cfg == 1) ? 1 : 0;
        take    = !(k == 1 && hwal == 1);
        if (!take) begin
          vexp = 4'd0; ps_exp = ps0; cexp = 32'h3F; fexp = 32'h5A5A_0000;
          e1exp = 0; dexp = 0;
        end else begin
          vexp   = ex ? 4'b0100 : (um ? 4'b0001 : 4'b0010);
          ps_exp = ps0 | 8'h10;
          case (k)
            0: cexp = {26'd0, cin};
            1: cexp = 32'd9;
            2: cexp = 32'd12;
            default: cexp = 32'd13;
          endcase
          if (k == 2)                fexp = p;
          else if (k != 0 || vvb==1) fexp = v;
          else                       fexp = 32'h5A5A_0000;
          e1exp = (ex == 0 || hasdepc == 0) ? p : 32'd0;
          dexp  = (ex == 1 && hasdepc == 1) ? p : 32'd0;
        end
        chk($sformatf("R2/R3 vector it%0d cfg%0d", it, cfg), {28'd0, g_v[cfg]}, {28'd0, vexp});
        chk($sformatf("R4 status it%0d cfg%0d", it, cfg), g_ps[cfg], {24'd0, ps_exp});
        chk($sformatf("R5/R6/R7 cause it%0d cfg%0d", it, cfg), g_c[cfg], cexp);
        chk($sformatf("R5/R6/R7 fault addr it%0d cfg%0d", it, cfg), g_f[cfg], fexp);
        chk($sformatf("R2 saved pc1 it%0d cfg%0d", it, cfg), g_e1[cfg], e1exp);
        chk($sformatf("R3 double pc it%0d cfg%0d", it, cfg), g_d[cfg], dexp);
      end
    end

    // Debug priority sweep (R8, R9)
    for (int il = 0; il < 8; il++) begin
      for (int l = 0; l < 8; l++) begin
        ps0 = 8'(il | ((l & 1) << 5));
        p   = 32'h0000_2000 + 32'((il * 8 + l) * 4);
        take = (il < l) && (l >= 2) && (l <= 6);
        wr(5'd0, {24'd0, ps0});
        wr(5'd4, 32'h3F);
        if (l >= 1 && l <= 6) begin
          wr(5'(8 + l), 32'd0);
          wr(5'(16 + l), 32'd0);
        end
        fire(1'b0, 2'd0, 6'd0, p, 32'd0, 1'b0, 1'b1, 6'(il * 8 + l), 4'(l));
        chk($sformatf("R8 debug vector il%0d L%0d", il, l), {28'd0, vcap_a},
            take ? 32'h8 : 32'h0);
        chk($sformatf("R9 debug status il%0d L%0d", il, l), {24'd0, pscap_a},
            take ? {24'd0, (ps0 & 8'hF0) | 8'(l) | 8'h10} : {24'd0, ps0});
        rd(5'd4);
        chk($sformatf("R9 debug cause il%0d L%0d", il, l), ra,
            take ? 32'(il * 8 + l) : 32'h3F);
        if (take) begin
          rd(5'(8 + l));  chk($sformatf("R9 saved pc L%0d", l), ra, p);
          rd(5'(16 + l)); chk($sformatf("R9 saved status L%0d", l), ra, {24'd0, ps0});
        end
      end
    end

    // Coincident fault and debug request (R10)
    wr(5'd0, 32'd0);
    @(negedge clk);
    raise = 1; kind = 0; cause = 6'd5; pc = 32'hA000_0000; dbg = 1; dcause = 6'd3; dlvl = 4'd3;
    @(negedge clk);
    chk("R10 fault vector first", {28'd0, vec_a}, 32'h2);
    raise = 0; dbg = 0; pc = 32'hB000_0000;
    @(negedge clk);
    chk("R10 pending debug next cycle", {28'd0, vec_a}, 32'h8);
    chk("R10 status after debug", {24'd0, ps_a}, 32'h13);
    @(negedge clk);
    chk("R11 vector idle after pair", {28'd0, vec_a}, 32'h0);
    rd(5'd9);  chk("R10 saved pc1", ra, 32'hA000_0000);
    rd(5'd11); chk("R10 saved pc3", ra, 32'hB000_0000);
    rd(5'd19); chk("R10 saved status3", ra, 32'h10);
    rd(5'd4);  chk("R10 debug cause", ra, 32'd3);
    rd(5'd1);  chk("R10 fault cause", ra, 32'd5);

    // R13 state holds while idle
    repeat (20) @(negedge clk);
    rd(5'd9);  chk("R13 saved pc1 held", ra, 32'hA000_0000);
    rd(5'd11); chk("R13 saved pc3 held", ra, 32'hB000_0000);
    chk("R13 status held", {24'd0, ps_a}, 32'h13);

    // R12 software write in an event cycle is dropped
    wr(5'd0, 32'd0);
    @(negedge clk);
    raise = 1; kind = 0; cause = 6'd7; pc = 32'hC000_0000;
    we = 1; addr = 5'd1; wdata = 32'h22;
    @(negedge clk);
    raise = 0; we = 0;
    rd(5'd1); chk("R12 write dropped under event", ra, 32'd7);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule